// File: doc/BRIEF.md
# Write Unlock Sequence Detector

This block guards the programming path of a page-programmed non-volatile memory. It watches every bus write, given as a one-cycle strobe with address and data, and follows a fixed three-write command sequence. Each step compares the low address bits and the data byte against a parameterised command pair. When the third pair arrives in order, the block issues a one-cycle grant pulse. That pulse opens a single sector-load session in a separate load controller, and the load controller reports the end of the session on a done input. Each program operation needs the full sequence again.

A write that breaks the sequence is rejected. It may be a plain write with no sequence before it, or a command write with the wrong address or data. A rejected write stores nothing. It produces a one-cycle reject pulse and starts a dummy write-timer period, and a poll flag stays high through that period so that reads can be answered as polling reads. A command write that arrives too long after the previous one does not continue the sequence. The detector falls back to its first step, so a protection that has been set up is never dropped by a stall.

Top module: `unlock_seq_detector`

## Requirements
- R1: After reset, grant, reject and pollActive are low, and the detector is locked: the first write that is not the first command pair is rejected.
- R2: Three writes whose low CMD_AW address bits and data equal, in order, step 0 (default 5555h/AAh), step 1 (default 2AAAh/55h) and step 2 (default 5555h/A0h) raise grant in the cycle after the strobe of the third write. A third write with any other data does not raise grant.
- R3: Address bits at and above CMD_AW play no part in matching.
- R4: A write whose address or data mismatches the expected pair, at any of the three steps, raises reject in the cycle after its strobe and returns the detector to step 0. Grant does not rise.
- R5: A rejected write sets pollActive high for exactly TWC_CYCLES clock cycles, starting in the cycle after its strobe.
- R6: While pollActive is high, writes are ignored: they cause no grant and no reject, and they do not advance the sequence.
- R7: After a grant, writes are byte loads and cause no grant and no reject until sessionDone. After that the unlock is used up, so a write without a new sequence is rejected.
- R8: A command write is taken as the next step only if it arrives within GAP_LIMIT cycles of the previous accepted command write (d ≤ GAP_LIMIT, where d counts clock edges from strobe to strobe). A later write is judged against step 0.
- R9: Grant and reject are never high in the same cycle, and each is high for exactly one cycle.
- R10: sessionDone outside a session has no effect on a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle pulse marking a bus write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| sessionDone | input | 1 | Load controller finished its program cycle |
| grant | output | 1 | One-cycle pulse opening a sector-load session |
| reject | output | 1 | One-cycle pulse for a refused write |
| pollActive | output | 1 | High during the dummy write-timer period |

## Verification
The bench builds the block with GAP_LIMIT=8 and TWC_CYCLES=12, and keeps ADDR_W=17 and CMD_AW=15. These short windows make it possible to sweep every strobe-to-strobe gap from 1 to GAP_LIMIT+2 at each step boundary, and to measure the full poll period cycle by cycle. The small data width allows all 256 data values at the final step. It also allows every mismatch type at every step and all four patterns of the high address bits.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;
  localparam int NUM_STEPS = 3;
  localparam int STEP_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARM1    = 2'd1,
    ST_ARM2    = 2'd2,
    ST_SESSION = 2'd3
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrGap;
    logic runGap;
    logic startDummy;
  } ctrlStrobes_t;

  // datapath -> control status
  typedef struct packed {
    logic hit;
    logic gapExpired;
    logic pollBusy;
  } dpStatus_t;
endpackage

// File: rtl/unlock_seq_dp.sv
module unlock_seq_dp
  import unlock_seq_pkg::*;
#(
  parameter int CMD_AW = 15,
  parameter int DATA_W = 8,
  parameter logic [31:0] CMD_ADDR0 = 32'h5555,
  parameter logic [31:0] CMD_ADDR1 = 32'h2AAA,
  parameter logic [31:0] CMD_ADDR2 = 32'h5555,
  parameter logic [DATA_W-1:0] CMD_DATA0 = 8'hAA,
  parameter logic [DATA_W-1:0] CMD_DATA1 = 8'h55,
  parameter logic [DATA_W-1:0] CMD_DATA2 = 8'hA0,
  parameter int GAP_LIMIT = 30000,
  parameter int TWC_CYCLES = 2000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CMD_AW-1:0]  cmdAddrLo,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [STEP_W-1:0]  stepIdx,
  input  ctrlStrobes_t       strobes,
  output dpStatus_t          status
);
  localparam int GW = $clog2(GAP_LIMIT + 1);
  localparam int TW = $clog2(TWC_CYCLES + 1);
  localparam logic [CMD_AW-1:0] STEP_ADDR [NUM_STEPS] =
    '{CMD_ADDR0[CMD_AW-1:0], CMD_ADDR1[CMD_AW-1:0], CMD_ADDR2[CMD_AW-1:0]};
  localparam logic [DATA_W-1:0] STEP_DATA [NUM_STEPS] =
    '{CMD_DATA0, CMD_DATA1, CMD_DATA2};

  logic [NUM_STEPS-1:0] hitVec;
  logic [GW-1:0] gapCnt;
  logic [TW-1:0] dummyCnt;

  // one comparator per command step
  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
    assign hitVec[i] = (cmdAddrLo == STEP_ADDR[i]) && (wrData == STEP_DATA[i]);
  end

  always_comb begin
    status.hit = 1'b0;
    for (int i = 0; i < NUM_STEPS; i++) begin
      if (stepIdx == STEP_W'(i)) status.hit = hitVec[i];
    end
  end

  // inter-write gap counter, saturating at the limit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gapCnt <= '0;
    end else if (strobes.clrGap) begin
      gapCnt <= '0;
    end else if (strobes.runGap && (gapCnt < GW'(GAP_LIMIT))) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assign status.gapExpired = (gapCnt >= GW'(GAP_LIMIT));

  // dummy write-timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dummyCnt <= '0;
    end else if (strobes.startDummy) begin
      dummyCnt <= TW'(TWC_CYCLES);
    end else if (dummyCnt != '0) begin
      dummyCnt <= dummyCnt - 1'b1;
    end
  end

  assign status.pollBusy = (dummyCnt != '0);

  // R8
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gapCnt <= GW'(GAP_LIMIT));
  // R5
  poll_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.startDummy |=> status.pollBusy);
  // R5
  poll_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status.pollBusy) |-> $past(strobes.startDummy));
endmodule

// File: rtl/unlock_seq_ctrl.sv
module unlock_seq_ctrl
  import unlock_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic              sessionDone,
  input  dpStatus_t         status,
  output logic [STEP_W-1:0] stepIdx,
  output ctrlStrobes_t      strobes,
  output logic              grant,
  output logic              reject
);
  seqState_t state, stateNext;
  logic grantNext, rejectNext;
  logic armed;

  assign armed = (state == ST_ARM1) || (state == ST_ARM2);

  always_comb begin
    unique case (state)
      ST_ARM1: stepIdx = status.gapExpired ? 2'd0 : 2'd1;
      ST_ARM2: stepIdx = status.gapExpired ? 2'd0 : 2'd2;
      default: stepIdx = 2'd0;
    endcase
  end

  always_comb begin
    stateNext  = state;
    grantNext  = 1'b0;
    rejectNext = 1'b0;
    strobes    = '0;
    strobes.runGap = armed;
    if (armed && status.gapExpired) stateNext = ST_IDLE;
    if (state == ST_SESSION) begin
      if (sessionDone) stateNext = ST_IDLE;
    end else if (wrStrobe && !status.pollBusy) begin
      if (status.hit) begin
        strobes.clrGap = 1'b1;
        unique case (stepIdx)
          2'd0:    stateNext = ST_ARM1;
          2'd1:    stateNext = ST_ARM2;
          default: begin
            stateNext = ST_SESSION;
            grantNext = 1'b1;
          end
        endcase
      end else begin
        stateNext          = ST_IDLE;
        rejectNext         = 1'b1;
        strobes.startDummy = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      grant  <= 1'b0;
      reject <= 1'b0;
    end else begin
      state  <= stateNext;
      grant  <= grantNext;
      reject <= rejectNext;
    end
  end

  // R9
  grant_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));
  // R9
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  // R9
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject);
  // R2
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ($past(wrStrobe) && ($past(state) == ST_ARM2)));
  // R6
  poll_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrStrobe && status.pollBusy) |=> (!grant && !reject));
  // R7
  session_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SESSION) |=> (!grant && !reject));
endmodule

// File: rtl/unlock_seq_detector.sv
module unlock_seq_detector
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMD_AW = 15,
  parameter int DATA_W = 8,
  parameter logic [31:0] CMD_ADDR0 = 32'h5555,
  parameter logic [31:0] CMD_ADDR1 = 32'h2AAA,
  parameter logic [31:0] CMD_ADDR2 = 32'h5555,
  parameter logic [DATA_W-1:0] CMD_DATA0 = 8'hAA,
  parameter logic [DATA_W-1:0] CMD_DATA1 = 8'h55,
  parameter logic [DATA_W-1:0] CMD_DATA2 = 8'hA0,
  parameter int GAP_LIMIT = 30000,
  parameter int TWC_CYCLES = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sessionDone,
  output logic              grant,
  output logic              reject,
  output logic              pollActive
);
  ctrlStrobes_t strobes;
  dpStatus_t status;
  logic [STEP_W-1:0] stepIdx;
  logic unusedAddrHi;

  // R3: high address bits are not compared
  assign unusedAddrHi = ^wrAddr[ADDR_W-1:CMD_AW];

  unlock_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .sessionDone(sessionDone),
    .status(status), .stepIdx(stepIdx), .strobes(strobes),
    .grant(grant), .reject(reject)
  );

  unlock_seq_dp #(
    .CMD_AW(CMD_AW), .DATA_W(DATA_W),
    .CMD_ADDR0(CMD_ADDR0), .CMD_ADDR1(CMD_ADDR1), .CMD_ADDR2(CMD_ADDR2),
    .CMD_DATA0(CMD_DATA0), .CMD_DATA1(CMD_DATA1), .CMD_DATA2(CMD_DATA2),
    .GAP_LIMIT(GAP_LIMIT), .TWC_CYCLES(TWC_CYCLES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmdAddrLo(wrAddr[CMD_AW-1:0]), .wrData(wrData),
    .stepIdx(stepIdx), .strobes(strobes), .status(status)
  );

  assign pollActive = status.pollBusy;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!grant && !reject && !pollActive));
endmodule

// File: tb/unlock_seq_detector_bench.sv
`timescale 1ns/1ps
module unlock_seq_detector_bench;
  localparam int GAP = 8;
  localparam int TWC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrStrobe = 1'b0;
  logic [16:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic sessionDone = 1'b0;
  logic grant, reject, pollActive;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  unlock_seq_detector #(.ADDR_W(17), .CMD_AW(15), .DATA_W(8),
    .GAP_LIMIT(GAP), .TWC_CYCLES(TWC)) u_unlock_seq_detector (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .sessionDone(sessionDone),
    .grant(grant), .reject(reject), .pollActive(pollActive));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe sampled at the next posedge; returns at the negedge after it
  task automatic doWrite(input logic [16:0] a, input logic [7:0] d);
    wrStrobe = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitPoll();
    for (int i = 0; i < 100 && pollActive; i++) @(negedge clk);
  endtask

  task automatic endSession();
    sessionDone = 1'b1; @(negedge clk); sessionDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [16:0] badA;
    logic [7:0] badD;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 grant", grant, 0);
    check("R1 reject", reject, 0);
    check("R1 poll", pollActive, 0);
    rst_n = 1'b1; @(negedge clk);
    doWrite(17'h01234, 8'h77);
    check("R1 locked reject", reject, 1);
    waitPoll();

    // R2 basic unlock + R9 pulse width
    doWrite(17'h05555, 8'hAA); check("R2 step0 quiet", grant | reject, 0);
    doWrite(17'h02AAA, 8'h55); check("R2 step1 quiet", grant | reject, 0);
    doWrite(17'h05555, 8'hA0); check("R2 grant", grant, 1);
    check("R9 no reject with grant", reject, 0);
    @(negedge clk); check("R9 grant one cycle", grant, 0);

    // R7 session: loads ignored, then used up
    for (int i = 0; i < 20; i++) begin
      doWrite(17'(i * 131), 8'(i * 7));
      check("R7 load quiet", grant | reject, 0);
    end
    endSession();
    doWrite(17'h00100, 8'h11);
    check("R7 consumed reject", reject, 1);
    @(negedge clk); check("R9 reject one cycle", reject, 0);
    waitPoll();

    // R5 poll length
    doWrite(17'h00042, 8'h99);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (pollActive) cnt++;
      @(negedge clk);
    end
    check("R5 poll length", cnt, TWC);

    // R6 writes during poll ignored
    doWrite(17'h00007, 8'h01);
    doWrite(17'h05555, 8'hAA); check("R6 quiet a", grant | reject, 0);
    doWrite(17'h02AAA, 8'h55); check("R6 quiet b", grant | reject, 0);
    doWrite(17'h05555, 8'hA0); check("R6 no grant", grant | reject, 0);
    waitPoll();
    doWrite(17'h02AAA, 8'h55);
    check("R6 sequence not advanced", reject, 1);
    waitPoll();

    // R2 sweep of final data byte
    for (int d = 0; d < 256; d++) begin
      doWrite(17'h05555, 8'hAA);
      doWrite(17'h02AAA, 8'h55);
      doWrite(17'h05555, 8'(d));
      check("R2 final data sweep grant", grant, (d == 'hA0) ? 1 : 0);
      check("R4 final data sweep reject", reject, (d == 'hA0) ? 0 : 1);
      if (d == 'hA0) endSession(); else waitPoll();
    end

    // R4 mismatch at each step, address or data
    for (int s = 0; s < 3; s++) begin
      for (int kind = 0; kind < 2; kind++) begin
        if (s > 0) doWrite(17'h05555, 8'hAA);
        if (s > 1) doWrite(17'h02AAA, 8'h55);
        case (s)
          0: begin badA = 17'h05555; badD = 8'hAA; end
          1: begin badA = 17'h02AAA; badD = 8'h55; end
          default: begin badA = 17'h05555; badD = 8'hA0; end
        endcase
        if (kind == 0) badA = badA ^ 17'h00001; else badD = badD ^ 8'h80;
        doWrite(badA, badD);
        check("R4 mismatch reject", reject, 1);
        check("R4 mismatch no grant", grant, 0);
        waitPoll();
        doWrite(17'h05555, 8'hA0);
        check("R4 back to step0", reject, 1);
        waitPoll();
      end
    end

    // R3 high address bits ignored
    for (int h = 0; h < 4; h++) begin
      doWrite({2'(h), 15'h5555}, 8'hAA);
      doWrite({2'(3 - h), 15'h2AAA}, 8'h55);
      doWrite({2'(h ^ 1), 15'h5555}, 8'hA0);
      check("R3 high bits grant", grant, 1);
      endSession();
    end

    // R8 gap sweep between step0 and step1
    for (int d = 1; d <= GAP + 2; d++) begin
      doWrite(17'h05555, 8'hAA);
      idle(d - 1);
      doWrite(17'h02AAA, 8'h55);
      check("R8 gap01 reject", reject, (d > GAP) ? 1 : 0);
      if (d > GAP) waitPoll();
      else begin
        doWrite(17'h05555, 8'hA0);
        check("R8 gap01 grant", grant, 1);
        endSession();
      end
    end
    // R8 gap sweep between step1 and step2
    for (int d = 1; d <= GAP + 2; d++) begin
      doWrite(17'h05555, 8'hAA);
      doWrite(17'h02AAA, 8'h55);
      idle(d - 1);
      doWrite(17'h05555, 8'hA0);
      check("R8 gap12 grant", grant, (d > GAP) ? 0 : 1);
      check("R8 gap12 reject", reject, (d > GAP) ? 1 : 0);
      if (d > GAP) waitPoll(); else endSession();
    end
    // R8 late write equal to step0 restarts the sequence
    doWrite(17'h05555, 8'hAA);
    idle(GAP);
    doWrite(17'h05555, 8'hAA);
    check("R8 restart quiet", grant | reject, 0);
    doWrite(17'h02AAA, 8'h55);
    doWrite(17'h05555, 8'hA0);
    check("R8 restart grant", grant, 1);
    endSession();

    // R10 sessionDone outside a session
    doWrite(17'h05555, 8'hAA);
    endSession();
    doWrite(17'h02AAA, 8'h55);
    doWrite(17'h05555, 8'hA0);
    check("R10 done ignored", grant, 1);
    endSession();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule